// File: doc/BRIEF.md
# Memory-Copy Channel Claim and Control Registers

This block is the register slice of a multi-channel memory-copy engine. Software reaches it over a plain byte-addressed register bus with 32-bit data. The address space is split into windows of 0x80 bytes. Window 0 holds two read-only global registers: the number of channels and the transfer-size scale. Channel `i`, counting from 0, sits in the window that starts at `0x80*(i+1)`.

Each channel window holds the following registers:
- A control register whose in-use bit is claimed by the act of reading it. The read returns the value from before the claim, so the first reader sees 0 and owns the channel, and any later reader sees 1.
- Three error-handling enables.
- A sticky error register with write-one-to-clear bits, fed by the engine.
- A write-only command port that turns START, APPEND and RESET codes into one-cycle pulses for the engine.
- A 64-bit completion-writeback address, loaded as two 32-bit halves.

A transfer-size scale `s` means each descriptor carries at most 2^s bytes. The value `s = 0` means there is no limit.

Top module: `dmach_regs`

## Requirements
- R1: A read of channel control (window offset 0x00) returns the register's value from before the access, with the in-use bit at bit 8, and sets the in-use bit at that same access. A returned bit 8 of 0 means the reader now owns the channel.
- R2: A write to channel control loads bit 8 (in-use), bit 3 (interrupt on error), bit 2 (abort on any error) and bit 0 (completion write on error) from the write data. All other control bits read as 0. Writing bit 8 as 0 releases the channel.
- R3: The channel error register (offset 0x08, 32 bits) sets a bit for each bit pulsed on the engine error input, and the bit stays set. Writing 1 to a bit clears it. A bit that the engine reports in the same cycle as a clear of that bit stays set.
- R4: A command write (offset 0x04) whose low byte is 0x01 gives a one-cycle START pulse. A low byte of 0x02 gives an APPEND pulse and 0x20 gives a RESET pulse. The pulse is on that channel's output in the cycle after the write. Any other code gives no pulse.
- R5: A RESET command clears that channel's error register and leaves its in-use bit and its enables unchanged.
- R6: The completion address low half (offset 0x10) and high half (offset 0x14) are each written on their own. A write to one half leaves the other half unchanged. Both halves read back.
- R7: Channel `i` answers only at window `i+1`. An access to one window changes no other channel's state.
- R8: Window 0 returns the channel count at offset 0x00 and the transfer-size scale at offset 0x04, both as 8-bit read-only values.
- R9: Reads of unmapped offsets, or of windows beyond the last channel, return 0. Writes to them change nothing.
- R10: Read data and the read-valid strobe appear in the cycle after the read request. A write requested in the same cycle as a read is ignored.
- R11: After reset, every channel is unowned, all enables, errors, addresses and pulses are 0, and read-valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (9) | Byte address of the access |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| eng_err | input | NUM_CH*32 | Per-channel error report pulses from the engine |
| ch_owned | output | NUM_CH | In-use bit of each channel |
| ch_err_irq_en | output | NUM_CH | Interrupt-on-error enable per channel |
| ch_abort_en | output | NUM_CH | Abort-on-any-error enable per channel |
| ch_cmpl_en | output | NUM_CH | Completion-write-on-error enable per channel |
| ch_cmpl_addr | output | NUM_CH*64 | Completion writeback address per channel |
| ch_start | output | NUM_CH | START pulse per channel |
| ch_append | output | NUM_CH | APPEND pulse per channel |
| ch_reset | output | NUM_CH | RESET pulse per channel |

## Verification
A wrong in-use bit shows up on `ch_owned` in the cycle after the access. The next control read also returns the wrong owner, so two agents could both think they hold the channel. A lost or stale error bit shows on the first error-register read after the engine report or the clear. A decode slip shows as a pulse or an enable on the wrong channel in the cycle right after the write, and it is also visible on the completion address outputs.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  localparam int unsigned WIN_BYTES = 128;
  localparam int unsigned DATA_W    = 32;

  // channel window offsets
  localparam int unsigned OFF_CTRL    = 'h00;
  localparam int unsigned OFF_CMD     = 'h04;
  localparam int unsigned OFF_ERR     = 'h08;
  localparam int unsigned OFF_CMPL_LO = 'h10;
  localparam int unsigned OFF_CMPL_HI = 'h14;
  // global window offsets
  localparam int unsigned OFF_NCH     = 'h00;
  localparam int unsigned OFF_XSCALE  = 'h04;

  // control bit positions
  localparam int unsigned BIT_INUSE  = 8;
  localparam int unsigned BIT_ERRIRQ = 3;
  localparam int unsigned BIT_ABORT  = 2;
  localparam int unsigned BIT_CMPLEN = 0;

  // command codes
  localparam logic [7:0] CMD_START  = 8'h01;
  localparam logic [7:0] CMD_APPEND = 8'h02;
  localparam logic [7:0] CMD_RESET  = 8'h20;

  typedef struct packed {
    logic in_use;
    logic err_irq;
    logic abort;
    logic cmpl_en;
  } ctrl_t;

  typedef struct packed {
    logic start;
    logic append;
    logic reset;
  } cmd_pulse_t;
endpackage

// File: rtl/dmach_decode.sv
`timescale 1ns/1ps
module dmach_decode #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              glob_sel,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [OFF_W-1:0]  off
);
  localparam int unsigned WIN_W = ADDR_W - OFF_W;

  logic [WIN_W-1:0] win_idx;

  assign win_idx  = addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign glob_sel = (win_idx == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = (win_idx == WIN_W'(i + 1));
  end
endmodule

// File: rtl/dmach_chan.sv
`timescale 1ns/1ps
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int unsigned OFF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [31:0]       err_in,
  output logic [DATA_W-1:0] rdata,
  output logic              owned,
  output logic              irq_en,
  output logic              abort_en,
  output logic              cmpl_en,
  output logic [63:0]       cmpl_addr,
  output logic              start_p,
  output logic              append_p,
  output logic              reset_p
);
  ctrl_t      ctrl_q, ctrl_d;
  logic [31:0] err_q, err_d;
  logic [31:0] clo_q, clo_d, chi_q, chi_d;
  cmd_pulse_t pulse_q, pulse_d;

  logic wr_eff;
  logic hit_ctrl, hit_cmd, hit_err, hit_lo, hit_hi;
  logic rst_cmd;

  assign wr_eff   = wr && !rd;
  assign hit_ctrl = sel && (off == OFF_W'(OFF_CTRL));
  assign hit_cmd  = sel && (off == OFF_W'(OFF_CMD));
  assign hit_err  = sel && (off == OFF_W'(OFF_ERR));
  assign hit_lo   = sel && (off == OFF_W'(OFF_CMPL_LO));
  assign hit_hi   = sel && (off == OFF_W'(OFF_CMPL_HI));
  assign rst_cmd  = wr_eff && hit_cmd && (wdata[7:0] == CMD_RESET);

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (rd && hit_ctrl) begin
      ctrl_d.in_use = 1'b1;
    end else if (wr_eff && hit_ctrl) begin
      ctrl_d.in_use  = wdata[BIT_INUSE];
      ctrl_d.err_irq = wdata[BIT_ERRIRQ];
      ctrl_d.abort   = wdata[BIT_ABORT];
      ctrl_d.cmpl_en = wdata[BIT_CMPLEN];
    end
  end

  always_comb begin
    err_d = err_q;
    if (rst_cmd) begin
      err_d = '0;
    end else if (wr_eff && hit_err) begin
      err_d = err_q & ~wdata;
    end
    err_d = err_d | err_in;
  end

  always_comb begin
    clo_d = clo_q;
    chi_d = chi_q;
    if (wr_eff && hit_lo) clo_d = wdata;
    if (wr_eff && hit_hi) chi_d = wdata;
  end

  always_comb begin
    pulse_d        = '0;
    pulse_d.start  = wr_eff && hit_cmd && (wdata[7:0] == CMD_START);
    pulse_d.append = wr_eff && hit_cmd && (wdata[7:0] == CMD_APPEND);
    pulse_d.reset  = rst_cmd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      err_q   <= '0;
      clo_q   <= '0;
      chi_q   <= '0;
      pulse_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      err_q   <= err_d;
      clo_q   <= clo_d;
      chi_q   <= chi_d;
      pulse_q <= pulse_d;
    end
  end

  // read view, value before any claim of this cycle
  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (off)
        OFF_W'(OFF_CTRL): begin
          rdata[BIT_INUSE]  = ctrl_q.in_use;
          rdata[BIT_ERRIRQ] = ctrl_q.err_irq;
          rdata[BIT_ABORT]  = ctrl_q.abort;
          rdata[BIT_CMPLEN] = ctrl_q.cmpl_en;
        end
        OFF_W'(OFF_ERR):     rdata = err_q;
        OFF_W'(OFF_CMPL_LO): rdata = clo_q;
        OFF_W'(OFF_CMPL_HI): rdata = chi_q;
        default:             rdata = '0;
      endcase
    end
  end

  assign owned     = ctrl_q.in_use;
  assign irq_en    = ctrl_q.err_irq;
  assign abort_en  = ctrl_q.abort;
  assign cmpl_en   = ctrl_q.cmpl_en;
  assign cmpl_addr = {chi_q, clo_q};
  assign start_p   = pulse_q.start;
  assign append_p  = pulse_q.append;
  assign reset_p   = pulse_q.reset;

  AST_CLAIM_SETS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_ctrl) |=> owned); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != '0) |=> ((err_q & $past(err_in)) == $past(err_in))); // R3
  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> $past(wr && !rd && sel && (off == OFF_W'(OFF_CMD)) && (wdata[7:0] == CMD_START))); // R4
  AST_RESET_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> ($stable(owned) && $stable(irq_en) && $stable(abort_en) && $stable(cmpl_en))); // R5
endmodule

// File: rtl/dmach_rdmux.sv
`timescale 1ns/1ps
module dmach_rdmux
  import dmach_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned OFF_W      = 7,
  parameter int unsigned XFER_SCALE = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  logic                     glob_sel,
  input  logic [OFF_W-1:0]         off,
  input  logic [NUM_CH-1:0]        ch_sel,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid
);
  logic [DATA_W-1:0] mux_d, rdata_q;
  logic              rvalid_q;

  always_comb begin
    mux_d = '0;
    if (glob_sel) begin
      if (off == OFF_W'(OFF_NCH))         mux_d[7:0] = 8'(NUM_CH);
      else if (off == OFF_W'(OFF_XSCALE)) mux_d[7:0] = 8'(XFER_SCALE);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) mux_d = mux_d | ch_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= mux_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned XFER_SCALE = 20,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES),
  localparam int unsigned ADDR_W    = $clog2(WIN_BYTES * (NUM_CH + 1))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CH*32-1:0]     eng_err,
  output logic [NUM_CH-1:0]        ch_owned,
  output logic [NUM_CH-1:0]        ch_err_irq_en,
  output logic [NUM_CH-1:0]        ch_abort_en,
  output logic [NUM_CH-1:0]        ch_cmpl_en,
  output logic [NUM_CH*64-1:0]     ch_cmpl_addr,
  output logic [NUM_CH-1:0]        ch_start,
  output logic [NUM_CH-1:0]        ch_append,
  output logic [NUM_CH-1:0]        ch_reset
);
  logic [1:0]               rst_sync;
  logic                     rst_int_n;
  logic                     glob_sel;
  logic [NUM_CH-1:0]        ch_sel;
  logic [OFF_W-1:0]         off;
  logic [NUM_CH*DATA_W-1:0] ch_rdata;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dmach_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .addr     (bus_addr),
    .glob_sel (glob_sel),
    .ch_sel   (ch_sel),
    .off      (off)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dmach_chan #(.OFF_W(OFF_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .sel       (ch_sel[i]),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .off       (off),
      .wdata     (bus_wdata),
      .err_in    (eng_err[i*32 +: 32]),
      .rdata     (ch_rdata[i*DATA_W +: DATA_W]),
      .owned     (ch_owned[i]),
      .irq_en    (ch_err_irq_en[i]),
      .abort_en  (ch_abort_en[i]),
      .cmpl_en   (ch_cmpl_en[i]),
      .cmpl_addr (ch_cmpl_addr[i*64 +: 64]),
      .start_p   (ch_start[i]),
      .append_p  (ch_append[i]),
      .reset_p   (ch_reset[i])
    );
  end

  dmach_rdmux #(.NUM_CH(NUM_CH), .OFF_W(OFF_W), .XFER_SCALE(XFER_SCALE)) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd       (bus_rd),
    .glob_sel (glob_sel),
    .off      (off),
    .ch_sel   (ch_sel),
    .ch_rdata (ch_rdata),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({glob_sel, ch_sel})); // R7
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rd |=> bus_rvalid); // R10
  AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rvalid |-> $past(bus_rd)); // R10
endmodule

// File: tb/dmach_regs_test.sv
`timescale 1ns/1ps
module dmach_regs_test;
  localparam int NCH = 2;
  localparam int XS  = 20;
  localparam int AW  = 9;

  logic            clk, rst_n;
  logic [AW-1:0]   bus_addr;
  logic            bus_rd, bus_wr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic            bus_rvalid;
  logic [NCH*32-1:0] eng_err;
  logic [NCH-1:0]  ch_owned, ch_err_irq_en, ch_abort_en, ch_cmpl_en;
  logic [NCH*64-1:0] ch_cmpl_addr;
  logic [NCH-1:0]  ch_start, ch_append, ch_reset;

  int errors = 0;
  int checks = 0;

  dmach_regs #(.NUM_CH(NCH), .XFER_SCALE(XS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .eng_err(eng_err), .ch_owned(ch_owned),
    .ch_err_irq_en(ch_err_irq_en), .ch_abort_en(ch_abort_en),
    .ch_cmpl_en(ch_cmpl_en), .ch_cmpl_addr(ch_cmpl_addr),
    .ch_start(ch_start), .ch_append(ch_append), .ch_reset(ch_reset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R10 rvalid", {63'd0, bus_rvalid}, 64'd1);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic err_pulse(input int ch, input logic [31:0] v);
    @(negedge clk);
    eng_err[ch*32 +: 32] = v;
    @(negedge clk);
    eng_err = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R11 owned", 64'(ch_owned), 64'd0);
    chk("R11 pulses", 64'({ch_start, ch_append, ch_reset}), 64'd0);
    chk("R11 cmpl addr", ch_cmpl_addr[63:0], 64'd0);
    chk("R11 enables", 64'({ch_err_irq_en, ch_abort_en, ch_cmpl_en}), 64'd0);
    chk("R11 rvalid", 64'(bus_rvalid), 64'd0);
    bus_read(9'h088, d);
    chk("R11 err", 64'(d), 64'd0);
  endtask

  task automatic t_claim();
    logic [31:0] d;
    bus_read(9'h080, d);
    chk("R1 first claim", 64'(d), 64'h000);
    chk("R1 owned after claim", 64'(ch_owned), 64'b01);
    bus_read(9'h080, d);
    chk("R1 second reader busy", 64'(d), 64'h100);
    bus_read(9'h100, d);
    chk("R7 ch1 independent", 64'(d), 64'h000);
    chk("R7 both owned", 64'(ch_owned), 64'b11);
  endtask

  task automatic t_ctrl_write();
    logic [31:0] d;
    bus_write(9'h080, 32'h0000_FFFF);
    bus_read(9'h080, d);
    chk("R2 writable bits", 64'(d), 64'h10D);
    chk("R2 enables", 64'({ch_err_irq_en[0], ch_abort_en[0], ch_cmpl_en[0]}), 64'b111);
    bus_write(9'h080, 32'h0000_000D);
    chk("R2 release", 64'(ch_owned), 64'b10);
    bus_read(9'h080, d);
    chk("R2 readback after release", 64'(d), 64'h00D);
    bus_write(9'h080, 32'h0000_000D);
    chk("R7 ch1 untouched", 64'({ch_owned, ch_err_irq_en[1]}), 64'b100);
  endtask

  task automatic t_error();
    logic [31:0] d;
    err_pulse(1, 32'h8000_0005);
    bus_read(9'h108, d);
    chk("R3 capture", 64'(d), 64'h8000_0005);
    bus_write(9'h108, 32'h0000_0001);
    bus_read(9'h108, d);
    chk("R3 w1c", 64'(d), 64'h8000_0004);
    @(negedge clk);
    bus_addr = 9'h108; bus_wdata = 32'h2; bus_wr = 1'b1; eng_err[63:32] = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; eng_err = '0;
    bus_read(9'h108, d);
    chk("R3 set beats clear", 64'(d), 64'h8000_0006);
    bus_write(9'h108, 32'h8000_0006);
    bus_read(9'h108, d);
    chk("R3 clear all", 64'(d), 64'h0);
  endtask

  task automatic t_cmd();
    bus_write(9'h084, 32'h01);
    chk("R4 start", 64'({ch_start, ch_append, ch_reset}), 64'b01_00_00);
    @(negedge clk);
    chk("R4 start one cycle", 64'(ch_start), 64'd0);
    bus_write(9'h104, 32'h02);
    chk("R4 append", 64'({ch_start, ch_append, ch_reset}), 64'b00_10_00);
    bus_write(9'h084, 32'h03);
    chk("R4 bad code", 64'({ch_start, ch_append, ch_reset}), 64'd0);
    bus_write(9'h104, 32'h20);
    chk("R4 reset", 64'({ch_start, ch_append, ch_reset}), 64'b00_00_10);
    @(negedge clk);
    chk("R4 reset one cycle", 64'(ch_reset), 64'd0);
  endtask

  task automatic t_reset_cmd();
    logic [31:0] d;
    bus_write(9'h100, 32'h109);
    err_pulse(1, 32'h0000_00F0);
    bus_write(9'h104, 32'h20);
    bus_read(9'h108, d);
    chk("R5 err cleared", 64'(d), 64'h0);
    chk("R5 owner kept", 64'(ch_owned[1]), 64'd1);
    chk("R5 enables kept", 64'({ch_err_irq_en[1], ch_abort_en[1], ch_cmpl_en[1]}), 64'b101);
  endtask

  task automatic t_cmpl();
    logic [31:0] d;
    bus_write(9'h090, 32'hDEAD_BEEF);
    bus_write(9'h094, 32'h1234_5678);
    chk("R6 full addr", ch_cmpl_addr[63:0], 64'h1234_5678_DEAD_BEEF);
    chk("R7 ch1 addr", ch_cmpl_addr[127:64], 64'd0);
    bus_write(9'h094, 32'hCAFE_F00D);
    chk("R6 high only", ch_cmpl_addr[63:0], 64'hCAFE_F00D_DEAD_BEEF);
    bus_read(9'h090, d);
    chk("R6 low readback", 64'(d), 64'hDEAD_BEEF);
  endtask

  task automatic t_global();
    logic [31:0] d;
    bus_read(9'h000, d);
    chk("R8 channel count", 64'(d), 64'(NCH));
    bus_read(9'h004, d);
    chk("R8 scale", 64'(d), 64'(XS));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [NCH-1:0] own0;
    own0 = ch_owned;
    bus_read(9'h08C, d);
    chk("R9 hole", 64'(d), 64'd0);
    bus_read(9'h180, d);
    chk("R9 beyond channels", 64'(d), 64'd0);
    bus_write(9'h180, 32'hFFFF_FFFF);
    bus_write(9'h098, 32'hFFFF_FFFF);
    bus_write(9'h000, 32'hFFFF_FFFF);
    chk("R9 no side effect addr", ch_cmpl_addr[63:0], 64'hCAFE_F00D_DEAD_BEEF);
    chk("R9 no side effect owner", 64'(ch_owned), 64'(own0));
    bus_read(9'h008, d);
    chk("R9 global hole", 64'(d), 64'd0);
    bus_read(9'h000, d);
    chk("R9 global read-only", 64'(d), 64'(NCH));
  endtask

  task automatic t_rd_wr();
    logic [31:0] d;
    @(negedge clk);
    bus_addr = 9'h090; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h1111_1111;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R10 data next cycle", 64'(bus_rdata), 64'hDEAD_BEEF);
    chk("R10 valid next cycle", 64'(bus_rvalid), 64'd1);
    @(negedge clk);
    chk("R10 valid drops", 64'(bus_rvalid), 64'd0);
    bus_read(9'h090, d);
    chk("R10 write ignored", 64'(d), 64'hDEAD_BEEF);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; eng_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_claim();
    t_ctrl_write();
    t_error();
    t_cmd();
    t_reset_cmd();
    t_cmpl();
    t_global();
    t_unmapped();
    t_rd_wr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule